// File: doc/BRIEF.md
# Reset Cause Recorder Register

This block is a memory-mapped control and status word that records which reset sources have fired since software last cleared them. Each source, an external pin, a brownout or shutdown exit, a software request, an independent watchdog, a window watchdog, an option-load sequence and an illegal low-power entry detector, delivers a one-cycle pulse that sets a sticky flag. The flags sit in a retained domain. Only the power-on reset `rst_ni` resets them, so they survive the system resets they record. Software clears all of them at once with a single command bit.

The same word holds two 4-bit oscillator range selectors that take effect after a standby exit. The legal codes are 6 (about 1.33 MHz), 8 (about 3.072 MHz), 4 (about 4 MHz, the default), 7 (about 1 MHz) and 5 (about 2 MHz). Every other code is reserved. A selector can be written only while the range-override input is high. A pin event or a brownout/shutdown-exit event returns it to code 4. A standby-exit strobe copies the stored codes to the oscillator outputs. These outputs stay in effect, flagged by an active signal, until the override is raised.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_ni` is low and directly after it, all flags are 0, both range fields and both range outputs hold code 4, `stby_rng_act_o` is 0, and `rd_data_o` reads 0x00000440.
- R2: A pulse on a cause input sets its flag on the next clock edge. The read bit positions are: option-load 25, pin 26, brownout/shutdown 27, software 28, independent watchdog 29, window watchdog 30, low-power 31.
- R3: A write with bit 24 set clears every flag on the next edge. A write with bit 24 clear leaves the flags unchanged. Bit 24 always reads 0.
- R4: When a cause pulse and a clear write arrive in the same cycle, that cause's flag is 1 afterwards.
- R5: Flags are sticky. Without a clear write, a set flag stays set whatever other inputs do.
- R6: Range field A is read at bits [11:8] and field B at bits [7:4]. A write updates them only while `rng_ovr_i` is 1.
- R7: A write whose field value lies outside 4..8 leaves that field unchanged. Each field is validated separately.
- R8: A pin or brownout/shutdown-exit pulse returns both range fields to code 4 on the next edge. This takes priority over a write in the same cycle.
- R9: `rng_a_o` and `rng_b_o` take the stored field values only on a `stby_exit_i` cycle. Writing a field does not change them.
- R10: `stby_rng_act_o` goes to 1 after a standby-exit cycle and to 0 after any cycle with `rng_ovr_i` high. The override wins when both occur together.
- R11: Bits [23:12] and [3:0] of `rd_data_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of the retained domain |
| evt_optld_i | input | 1 | Option-load reset pulse |
| evt_pin_i | input | 1 | External pin reset pulse |
| evt_bor_i | input | 1 | Brownout or shutdown-exit reset pulse |
| evt_sw_i | input | 1 | Software reset pulse |
| evt_iwdg_i | input | 1 | Independent watchdog reset pulse |
| evt_wwdg_i | input | 1 | Window watchdog reset pulse |
| evt_lpwr_i | input | 1 | Illegal low-power entry reset pulse |
| stby_exit_i | input | 1 | Standby-exit strobe |
| rng_ovr_i | input | 1 | Range override; enables field writes and ends stored-range use |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| rng_a_o | output | 4 | Range code applied to oscillator A |
| rng_b_o | output | 4 | Range code applied to oscillator B |
| stby_rng_act_o | output | 1 | Stored ranges currently in effect |

## Verification
On every cycle, the assertions check that flags are set by their pulses, that they stay sticky without a clear, and that a clear leaves only the same-cycle pulses. They also check that the fields never hold a reserved code, that they do not move without a gated write or a default event, and that the applied outputs change only on a standby exit. Some behaviours only the bench's scenarios can show: the bit layout seen at the read port, the exact values that reach the applied outputs, the priority of a default event over a write, and the reset image.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FLAG_CNT  = 7;
  localparam int unsigned RNG_W     = 4;
  localparam int unsigned RNG_CNT   = 2;
  localparam int unsigned CLR_BIT   = 24;
  localparam int unsigned FLAG_LSB  = 25;
  localparam int unsigned RNG_A_LSB = 8;
  localparam int unsigned RNG_B_LSB = 4;
  localparam logic [RNG_W-1:0] RNG_DEF = 4'd4;
  localparam logic [RNG_W-1:0] RNG_MIN = 4'd4;
  localparam logic [RNG_W-1:0] RNG_MAX = 4'd8;

  typedef enum int unsigned {
    F_OPT  = 0,
    F_PIN  = 1,
    F_BOR  = 2,
    F_SW   = 3,
    F_IWDG = 4,
    F_WWDG = 5,
    F_LPWR = 6
  } flag_idx_e;

  typedef logic [RNG_W-1:0] rng_code_t;

  function automatic logic rng_ok(input rng_code_t c);
    return (c >= RNG_MIN) && (c <= RNG_MAX);
  endfunction
endpackage

// File: rtl/rst_flag_bank.sv
module rst_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i)    flags_o[i] <= 1'b0;
    end
  end

  // R2 R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> ((flags_o & $past(set_i)) == $past(set_i)));
  // R3
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_o == $past(set_i)));
  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/rng_field.sv
module rng_field
  import rst_cause_pkg::*;
#(
  parameter rng_code_t DEF = RNG_DEF
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  rng_code_t code_i,
  input  logic      force_def_i,
  output rng_code_t code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       code_o <= DEF;
    else if (force_def_i)              code_o <= DEF;
    else if (wr_i && rng_ok(code_i))   code_o <= code_i;
  end

  // R7
  rng_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_ok(code_o));
  // R6
  rng_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !force_def_i) |=> $stable(code_o));
  // R8
  rng_def_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_def_i |=> (code_o == DEF));
endmodule

// File: rtl/rng_apply.sv
module rng_apply
  import rst_cause_pkg::*;
#(
  parameter int unsigned NF = RNG_CNT,
  parameter int unsigned W  = RNG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF*W-1:0] stored_i,
  input  logic          stby_exit_i,
  input  logic          ovr_i,
  output logic [NF*W-1:0] applied_o,
  output logic          act_o
);
  localparam logic [NF*W-1:0] APPLY_DEF = {NF{RNG_DEF}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          applied_o <= APPLY_DEF;
    else if (stby_exit_i) applied_o <= stored_i;
  end

  // override ends stored-range use, beats standby exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          act_o <= 1'b0;
    else if (ovr_i)       act_o <= 1'b0;
    else if (stby_exit_i) act_o <= 1'b1;
  end

  // R9
  apply_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_exit_i |=> $stable(applied_o));
  // R10
  act_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> !act_o);
  // R10
  act_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_exit_i && !ovr_i) |=> act_o);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_optld_i,
  input  logic             evt_pin_i,
  input  logic             evt_bor_i,
  input  logic             evt_sw_i,
  input  logic             evt_iwdg_i,
  input  logic             evt_wwdg_i,
  input  logic             evt_lpwr_i,
  input  logic             stby_exit_i,
  input  logic             rng_ovr_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [RNG_W-1:0] rng_a_o,
  output logic [RNG_W-1:0] rng_b_o,
  output logic             stby_rng_act_o
);
  logic [FLAG_CNT-1:0]      evt;
  logic [FLAG_CNT-1:0]      flags;
  logic                     clr_all;
  logic                     fld_wr;
  logic                     fld_def;
  logic [RNG_CNT*RNG_W-1:0] fld_q;
  logic [RNG_CNT*RNG_W-1:0] fld_app;

  always_comb begin
    evt         = '0;
    evt[F_OPT]  = evt_optld_i;
    evt[F_PIN]  = evt_pin_i;
    evt[F_BOR]  = evt_bor_i;
    evt[F_SW]   = evt_sw_i;
    evt[F_IWDG] = evt_iwdg_i;
    evt[F_WWDG] = evt_wwdg_i;
    evt[F_LPWR] = evt_lpwr_i;
  end

  assign clr_all = wr_en_i & wr_data_i[CLR_BIT];
  assign fld_wr  = wr_en_i & rng_ovr_i;
  assign fld_def = evt_pin_i | evt_bor_i;

  rst_flag_bank #(.N(FLAG_CNT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt),
    .clr_i   (clr_all),
    .flags_o (flags)
  );

  // slot 1 = field A, slot 0 = field B
  for (genvar g = 0; g < RNG_CNT; g++) begin : g_fld
    localparam int unsigned LSB = (g == 1) ? RNG_A_LSB : RNG_B_LSB;
    rng_field #(.DEF(RNG_DEF)) u_fld (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (fld_wr),
      .code_i      (wr_data_i[LSB +: RNG_W]),
      .force_def_i (fld_def),
      .code_o      (fld_q[g*RNG_W +: RNG_W])
    );
  end

  rng_apply #(.NF(RNG_CNT), .W(RNG_W)) u_apply (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stored_i    (fld_q),
    .stby_exit_i (stby_exit_i),
    .ovr_i       (rng_ovr_i),
    .applied_o   (fld_app),
    .act_o       (stby_rng_act_o)
  );

  assign rng_a_o = fld_app[RNG_W +: RNG_W];
  assign rng_b_o = fld_app[0 +: RNG_W];

  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[FLAG_LSB +: FLAG_CNT]   = flags;
    rd_data_o[RNG_A_LSB +: RNG_W]     = fld_q[RNG_W +: RNG_W];
    rd_data_o[RNG_B_LSB +: RNG_W]     = fld_q[0 +: RNG_W];
  end

  // R11 R3
  rd_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[23:12] == '0) && (rd_data_o[3:0] == '0) && !rd_data_o[CLR_BIT]);
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e_opt = 0, e_pin = 0, e_bor = 0, e_sw = 0, e_iw = 0, e_ww = 0, e_lp = 0;
  logic        stby = 0, ovr = 0, wr = 0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [3:0]  ra, rb;
  logic        act;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [6:0] m_flags;
  logic [3:0] m_a, m_b, m_oa, m_ob;
  logic       m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_optld_i(e_opt), .evt_pin_i(e_pin), .evt_bor_i(e_bor), .evt_sw_i(e_sw),
    .evt_iwdg_i(e_iw), .evt_wwdg_i(e_ww), .evt_lpwr_i(e_lp),
    .stby_exit_i(stby), .rng_ovr_i(ovr), .wr_en_i(wr), .wr_data_i(wd),
    .rd_data_o(rd), .rng_a_o(ra), .rng_b_o(rb), .stby_rng_act_o(act)
  );

  function automatic bit legal(input logic [3:0] c);
    return c >= 4 && c <= 8;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[31:25] = m_flags;
    v[11:8]  = m_a;
    v[7:4]   = m_b;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " rd"}, rd, exp_rd());
    chk({req, " out"}, {24'h0, ra, rb}, {24'h0, m_oa, m_ob});
    chk({req, " act"}, {31'h0, act}, {31'h0, m_act});
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic [6:0] ev, input logic s, input logic o,
                      input logic w, input logic [31:0] d, input string req);
    {e_lp, e_ww, e_iw, e_sw, e_bor, e_pin, e_opt} = ev;
    stby = s; ovr = o; wr = w; wd = d;
    @(posedge clk);
    if (w && d[24]) m_flags = '0;
    m_flags = m_flags | ev;
    if (s) begin m_oa = m_a; m_ob = m_b; end
    if (ev[1] || ev[2]) begin m_a = 4; m_b = 4; end
    else if (w && o) begin
      if (legal(d[11:8])) m_a = d[11:8];
      if (legal(d[7:4]))  m_b = d[7:4];
    end
    if (o) m_act = 0; else if (s) m_act = 1;
    @(negedge clk);
    {e_lp, e_ww, e_iw, e_sw, e_bor, e_pin, e_opt} = '0;
    stby = 0; ovr = 0; wr = 0; wd = '0;
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd12345));
    m_flags = '0; m_a = 4; m_b = 4; m_oa = 4; m_ob = 4; m_act = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 in reset", rd, 32'h0000_0440);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R2: each cause alone
    for (int i = 0; i < 7; i++) step(7'(1 << i), 0, 0, 0, '0, "R2 single cause");
    // R3: write with bit24 clear has no effect, then clear
    step('0, 0, 0, 1, 32'hFEFF_FFFF, "R3 no-clear write");
    step('0, 0, 0, 1, 32'h0100_0000, "R3 clear all");
    // R4: set beats clear
    step(7'b0001000, 0, 0, 1, 32'h0100_0000, "R4 set vs clear");
    // R5: sticky across events
    step(7'b1000000, 0, 0, 0, '0, "R5 sticky");
    // R6: gated write ignored, then accepted
    step('0, 0, 0, 1, 32'h0000_0650, "R6 write gated");
    step('0, 0, 1, 1, 32'h0000_0650, "R6 write ovr");
    // R7: reserved code in A only, then both
    step('0, 0, 1, 1, 32'h0000_0970, "R7 reserved A");
    step('0, 0, 1, 1, 32'h0000_0330, "R7 reserved both");
    // R9: applied unchanged by write, then standby copies
    step('0, 1, 0, 0, '0, "R9 stby apply");
    step('0, 0, 1, 1, 32'h0000_0840, "R9 write no apply");
    // R10: override and standby together
    step('0, 1, 1, 0, '0, "R10 ovr wins");
    // R8: pin event beats write
    step(7'b0000010, 0, 1, 1, 32'h0000_0780, "R8 pin default");
    step('0, 0, 1, 1, 32'h0000_0870, "R8 setup");
    step(7'b0000100, 0, 0, 0, '0, "R8 bor default");
    // R11 + random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0]  ev = '0;
      logic [31:0] d = $urandom;
      for (int b = 0; b < 7; b++) ev[b] = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 1) == 1) begin
        d[11:8] = 4'($urandom_range(3, 9));
        d[7:4]  = 4'($urandom_range(3, 9));
      end
      if ($urandom_range(0, 3) != 0) d[24] = 1'b0;
      step(ev, $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, d, "R11 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule